// File: doc/BRIEF.md
# Neighbor-Aware Parallel Interference Pattern Generator

This block produces the row data words for a memory-cell interference test once the physical neighbor distances of the cells are known. Each neighbor sits at a distance of 1 or 5 bit positions on either side. Cells spaced 11 apart never share a neighbor, so they can be tested together. In each pass the block marks one periodic set of victim bits. It drives every victim to 1 and every bit at a neighbor distance from a victim to 0. Eleven passes cover the whole row.

A single start pulse launches a sequence of passes. Each pass leaves the block as one beat on a valid/ready stream. A beat carries the row data word, a victim mask that a downstream checker uses to compare only the cells under test, and the pass number. Back-pressure rules are as follows. A beat is offered with `valid_o` high and stays unchanged until a cycle with `ready_i` high. The block moves to the next pass only on a cycle in which both `valid_o` and `ready_i` are high. `ready_i` may be held low for any number of cycles. A one-cycle `done_o` pulse follows acceptance of the last pass.

Top module: `nbr_pattern_gen`

## Requirements
- R1: After reset, `valid_o` and `done_o` are 0.
- R2: When idle (`valid_o` low), a high `start_i` makes `valid_o` high on the next cycle with `pass_o` = 0.
- R3: In the beat with `pass_o` = k, `mask_o` bit i is 1 exactly when i mod 11 equals k. Bit 0 is the least significant bit of the row.
- R4: In every beat, `data_o` bit i is 1 when i is a victim. A bit at distance 1 or 5 from a victim is 0, and any other bit is also 0. Neighbor positions below bit 0 or above the top bit are dropped, with no wrap-around.
- R5: While `valid_o` is high and `ready_i` is low, the next cycle still has `valid_o` high with `pass_o`, `data_o` and `mask_o` unchanged.
- R6: Each accepted beat other than the last is followed by a beat whose `pass_o` is one higher, so one sequence is exactly 11 beats, numbered 0 to 10.
- R7: Acceptance of the pass-10 beat makes `done_o` high for exactly the next cycle, with `valid_o` low in that cycle.
- R8: A `start_i` pulse while a sequence is in progress is ignored: the sequence continues without restarting.
- R9: A `start_i` in the cycle where `done_o` is high is accepted, and pass 0 is offered on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launches a pass sequence when idle |
| ready_i | input | 1 | Downstream accepts the offered beat |
| valid_o | output | 1 | A pass beat is offered |
| pass_o | output | 4 | Pass number of the offered beat |
| data_o | output | ROW_W (64) | Row data word for this pass |
| mask_o | output | ROW_W (64) | Victim bits for this pass |
| done_o | output | 1 | One-cycle pulse after the last pass is accepted |

## Verification
The end-of-sequence `done_o` pulse can fall in the same cycle as the acceptance of a fresh `start_i`. The bench provokes this by raising `start_i` exactly while `done_o` is high. It then checks that the next cycle offers pass 0, with the full expected pattern and no skipped or repeated pass. A start raised in the middle of a stalled sequence is also driven, and the scoreboard shows that the sequence carries on unchanged.

// File: rtl/nbr_pattern_pkg.sv
package nbr_pattern_pkg;

  // Number of bit positions in [0, row_w) that are congruent to k modulo period
  function automatic int victims_in_pass(input int row_w, input int period, input int k);
    return (row_w + period - 1 - k) / period;
  endfunction

endpackage

// File: rtl/nbr_pass_seq.sv
module nbr_pass_seq #(
  parameter int PERIOD = 11,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] pass_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PERIOD - 1);

  logic             active_q;
  logic [IDX_W-1:0] pass_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pass_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          pass_q   <= '0;
        end
      end else if (ready_i) begin
        if (pass_q == LAST) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          pass_q <= pass_q + 1'b1;
        end
      end
    end
  end

  assign valid_o = active_q;
  assign pass_o  = pass_q;
  assign done_o  = done_q;

  a_r2_start_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && start_i) |=> (valid_o && pass_o == '0));

  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(pass_o)));

  a_r6_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && pass_o != LAST) |=> (valid_o && pass_o == $past(pass_o) + 1'b1));

  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && pass_o == LAST) |=> (done_o && !valid_o));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_pass_range: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (pass_o <= LAST));

endmodule

// File: rtl/nbr_row_builder.sv
module nbr_row_builder
  import nbr_pattern_pkg::*;
#(
  parameter int ROW_W     = 64,
  parameter int DIST_NEAR = 1,
  parameter int DIST_FAR  = 5,
  parameter int PERIOD    = 11,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [IDX_W-1:0] pass_i,
  output logic [ROW_W-1:0] data_o,
  output logic [ROW_W-1:0] mask_o
);
  localparam int N_DIST = 2;
  localparam int DISTS [N_DIST] = '{DIST_NEAR, DIST_FAR};

  logic [ROW_W-1:0] victim;
  logic [ROW_W-1:0] nbr_hit;

  for (genvar i = 0; i < ROW_W; i++) begin : g_bit
    localparam int PHASE = i % PERIOD;
    logic [2*N_DIST-1:0] taps;

    assign victim[i] = (pass_i == IDX_W'(PHASE));

    for (genvar j = 0; j < N_DIST; j++) begin : g_dist
      if (i >= DISTS[j]) begin : g_lo
        assign taps[2*j] = victim[i - DISTS[j]];
      end else begin : g_lo_off
        assign taps[2*j] = 1'b0;
      end
      if (i + DISTS[j] < ROW_W) begin : g_hi
        assign taps[2*j+1] = victim[i + DISTS[j]];
      end else begin : g_hi_off
        assign taps[2*j+1] = 1'b0;
      end
    end

    assign nbr_hit[i] = |taps;
    assign data_o[i]  = victim[i] & ~nbr_hit[i];
  end

  assign mask_o = victim;

  a_r4_no_victim_on_neighbor: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |-> ((victim & nbr_hit) == '0));

  a_r3_victim_count: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |-> ($countones(mask_o) == victims_in_pass(ROW_W, PERIOD, int'(pass_i))));

  a_r4_data_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |-> ((data_o & ~mask_o) == '0));

endmodule

// File: rtl/nbr_pattern_gen.sv
module nbr_pattern_gen #(
  parameter int ROW_W     = 64,
  parameter int DIST_NEAR = 1,
  parameter int DIST_FAR  = 5,
  localparam int PERIOD   = 2 * DIST_FAR + 1,
  localparam int IDX_W    = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] pass_o,
  output logic [ROW_W-1:0] data_o,
  output logic [ROW_W-1:0] mask_o,
  output logic             done_o
);

  nbr_pass_seq #(
    .PERIOD (PERIOD),
    .IDX_W  (IDX_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ready_i (ready_i),
    .valid_o (valid_o),
    .pass_o  (pass_o),
    .done_o  (done_o)
  );

  nbr_row_builder #(
    .ROW_W     (ROW_W),
    .DIST_NEAR (DIST_NEAR),
    .DIST_FAR  (DIST_FAR),
    .PERIOD    (PERIOD),
    .IDX_W     (IDX_W)
  ) u_build (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_o),
    .pass_i  (pass_o),
    .data_o  (data_o),
    .mask_o  (mask_o)
  );

  a_r7_idle_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !valid_o);

  a_r5_data_stable_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> ($stable(data_o) && $stable(mask_o)));

endmodule

// File: tb/nbr_pattern_gen_tb.sv
module nbr_pattern_gen_tb;
  localparam int ROW_W = 64;
  localparam int NP    = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             ready_i = 1'b0;
  logic             valid_o;
  logic [3:0]       pass_o;
  logic [ROW_W-1:0] data_o;
  logic [ROW_W-1:0] mask_o;
  logic             done_o;

  int total = 0;
  int bad   = 0;
  int beats = 0;
  int cyc   = 0;
  bit rand_ready = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  int               exp_pass_q [$];
  logic [ROW_W-1:0] exp_mask_q [$];
  logic [ROW_W-1:0] exp_data_q [$];

  always #5 clk = ~clk;

  nbr_pattern_gen #(.ROW_W(ROW_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(ready_i),
    .valid_o(valid_o), .pass_o(pass_o), .data_o(data_o), .mask_o(mask_o),
    .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [ROW_W-1:0] act, input logic [ROW_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: expected beats for one full sequence
  task automatic push_sequence();
    for (int k = 0; k < NP; k++) begin
      logic [ROW_W-1:0] m;
      logic [ROW_W-1:0] d;
      m = '0;
      for (int i = 0; i < ROW_W; i++) if (i % NP == k) m[i] = 1'b1;
      d = '0;
      for (int i = 0; i < ROW_W; i++) begin
        if (m[i]) begin
          d[i] = 1'b1;
          if (i - 1 >= 0)    d[i-1] = 1'b0;
          if (i + 1 < ROW_W) d[i+1] = 1'b0;
          if (i - 5 >= 0)    d[i-5] = 1'b0;
          if (i + 5 < ROW_W) d[i+5] = 1'b0;
        end
      end
      exp_pass_q.push_back(k);
      exp_mask_q.push_back(m);
      exp_data_q.push_back(d);
    end
  endtask

  // Ready generation, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ready_i <= rand_ready ? lfsr[0] : 1'b1;
  end

  // Monitor
  logic             prev_stall = 1'b0;
  logic             prev_last  = 1'b0;
  logic [3:0]       held_pass;
  logic [ROW_W-1:0] held_data, held_mask;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        check(valid_o === 1'b1 && pass_o === held_pass && data_o === held_data
              && mask_o === held_mask, "R5", "beat changed under stall",
              {pass_o, data_o[59:0]}, {held_pass, held_data[59:0]});
      end
      if (done_o) begin
        check(prev_last && !valid_o, "R7", "done not right after last pass",
              ROW_W'({prev_last, valid_o}), ROW_W'(2'b10));
      end else begin
        check(!prev_last, "R7", "done missing after last pass", '0, '1);
      end
      prev_stall = 1'b0;
      prev_last  = 1'b0;
      if (valid_o) begin
        if (ready_i) begin
          if (exp_pass_q.size() == 0) begin
            check(1'b0, "R8", "unexpected beat", ROW_W'(pass_o), '0);
          end else begin
            int               ep;
            logic [ROW_W-1:0] em, ed;
            ep = exp_pass_q.pop_front();
            em = exp_mask_q.pop_front();
            ed = exp_data_q.pop_front();
            check(pass_o === 4'(ep), "R6", "pass index", ROW_W'(pass_o), ROW_W'(ep));
            check(mask_o === em, "R3", "victim mask", mask_o, em);
            check(data_o === ed, "R4", "row data", data_o, ed);
          end
          beats++;
          if (pass_o == 4'd10) prev_last = 1'b1;
        end else begin
          prev_stall = 1'b1;
          held_pass = pass_o;
          held_data = data_o;
          held_mask = mask_o;
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(posedge clk);
    #2 start_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(valid_o === 1'b0 && done_o === 1'b0, "R1", "reset state",
          ROW_W'({valid_o, done_o}), '0);

    // Run 1: ready always high
    push_sequence();
    @(negedge clk);
    pulse_start();
    @(negedge clk);
    check(valid_o === 1'b1 && pass_o === 4'd0, "R2", "start launch",
          ROW_W'({valid_o, pass_o}), ROW_W'(5'h10));
    wait_done();
    check(beats == 11, "R6", "beat count run 1", ROW_W'(beats), ROW_W'(11));

    // Run 2: random back-pressure, start pulses while busy
    rand_ready = 1'b1;
    repeat (2) @(negedge clk);
    push_sequence();
    pulse_start();
    repeat (4) @(negedge clk);
    pulse_start();   // R8: ignored while running
    repeat (7) @(negedge clk);
    pulse_start();   // R8: ignored while running
    // R9: start raised in the cycle that done is high
    wait_done();
    push_sequence();
    start_i = 1'b1;
    @(posedge clk);
    #2 start_i = 1'b0;
    @(negedge clk);
    check(valid_o === 1'b1 && pass_o === 4'd0, "R9", "start on done cycle",
          ROW_W'({valid_o, pass_o}), ROW_W'(5'h10));
    wait_done();
    check(beats == 33, "R8", "beat count after busy starts", ROW_W'(beats), ROW_W'(33));
    repeat (5) @(negedge clk);
    check(valid_o === 1'b0 && exp_pass_q.size() == 0, "R8", "idle, scoreboard empty",
          ROW_W'({valid_o, 4'(exp_pass_q.size())}), '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule